// File: doc/BRIEF.md
# External Output Latch Controller

This block widens a chip's set of output pins by driving a pair of write-only 8-bit transparent latches that sit outside the chip on the system data bus. Each latch takes its D inputs straight from the bus data lines and needs only a load strobe from this block, so no glue logic is required. Because the latches cannot be read back, the block keeps a 16-bit on-chip mirror of everything written to them. Software can then read the mirror, change the bits it needs and write the whole value back.

Requests arrive on a valid/ready port. An accepted request runs a fixed four-state bus cycle, T1 to T4. For a write to the mirror address, the write data is placed on the external data lines from T1 to T4. The strobe of each byte lane whose byte enable is set is high for the single T3 clock. The mirror bytes for those lanes take the new data at the end of T3. A one-cycle response in T4 returns the mirror contents. While reset is asserted both strobes are held high and the data lines are held at zero, so the external pins start cleared.

Back-pressure rules: `req_ready` is low from T1 through T4 and during reset. A request is taken in the cycle where `req_valid` and `req_ready` are both high. All request fields are captured at that point. The response has no ready signal, and `rsp_valid` is high for exactly one cycle.

Top module: `lext_ctrl`

## Requirements
- R1: `req_ready` is high exactly when out of reset and idle. After an acceptance it stays low for four cycles (T1..T4) and returns high in the following cycle.
- R2: While `rst_n` is low, both bits of `ext_stb` are 1, `ext_data` is 0, and `req_ready` and `rsp_valid` are 0.
- R3: After reset the mirror reads 0x0000.
- R4: Strobe bit i (bit 0 covers data bits 7:0, bit 1 covers 15:8) is high only in T3 of an accepted write (`req_write`=1) to address 0x40 with `req_be[i]`=1, for one cycle.
- R5: A write to any other address raises no strobe and leaves the mirror unchanged.
- R6: During T1..T4 of a mirror write, `ext_data` carries the captured write data and is stable. At all other times it is 0.
- R7: At the end of T3, each mirror byte whose enable is set takes the write byte. Bytes whose enable is clear keep their value.
- R8: `rsp_valid` is high for one cycle in T4. `rsp_rdata` is then the mirror (already updated) for address 0x40, and 0 for other addresses. Reads never strobe.
- R9: Changes to the request fields after acceptance do not affect the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Request address; mirror lives at 0x40 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables |
| rsp_valid | output | 1 | One-cycle response in T4 |
| rsp_rdata | output | 16 | Mirror contents, or 0 for other addresses |
| ext_data | output | 16 | Data lines feeding the external latches |
| ext_stb | output | 2 | Per-latch load strobes |

## Verification
The hardest situation to reach is a request whose fields change right after acceptance. It must still strobe and update the mirror with the captured values. The bench reaches it by corrupting address, data, enables and direction on the cycle after acceptance, then reading the mirror back. Partial byte-enable writes and a write with no enables show that untouched lanes keep their contents. A reset applied after the mirror holds data shows that strobes go high and the mirror clears. A reference model checks every output on every cycle.

// File: rtl/lext_pkg.sv
package lext_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;
endpackage

// File: rtl/lext_bus_seq.sv
module lext_bus_seq
  import lext_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LANES       = 2,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned MIRROR_ADDR = 'h40,
  localparam int unsigned DATA_W     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ready,
  output phase_e            phase,
  output logic              cap_write,
  output logic              cap_hit,
  output logic [DATA_W-1:0] cap_wdata,
  output logic [LANES-1:0]  cap_be
);
  phase_e phase_q;
  logic   addr_match;

  assign addr_match = (req_addr == ADDR_W'(MIRROR_ADDR));
  assign req_ready  = rst_n && (phase_q == PH_IDLE);
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cap_write <= 1'b0;
      cap_hit   <= 1'b0;
      cap_wdata <= '0;
      cap_be    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            phase_q   <= PH_T1;
            cap_write <= req_write;
            cap_hit   <= addr_match;
            cap_wdata <= req_wdata;
            cap_be    <= req_be;
          end
        end
        PH_T1:   phase_q <= PH_T2;
        PH_T2:   phase_q <= PH_T3;
        PH_T3:   phase_q <= PH_T4;
        PH_T4:   phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lext_strobe.sv
module lext_strobe
  import lext_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              cap_write,
  input  logic              cap_hit,
  input  logic [DATA_W-1:0] cap_wdata,
  input  logic [LANES-1:0]  cap_be,
  output logic [LANES-1:0]  lane_fire,
  output logic [LANES-1:0]  ext_stb,
  output logic [DATA_W-1:0] ext_data
);
  logic mirror_wr;
  logic in_t3;
  logic busy;

  assign mirror_wr = cap_write && cap_hit;
  assign in_t3     = (phase == PH_T3);
  assign busy      = (phase != PH_IDLE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_fire[i] = in_t3 && mirror_wr && cap_be[i];
    assign ext_stb[i]   = lane_fire[i] || !rst_n;
  end

  assign ext_data = (rst_n && busy && mirror_wr) ? cap_wdata : '0;
endmodule

// File: rtl/lext_mirror.sv
module lext_mirror #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  upd_lane,
  input  logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] mirror_q
);
  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[i] <= '0;
      end else if (upd_lane[i]) begin
        lane_q[i] <= upd_data[i*LANE_W +: LANE_W];
      end
    end
    assign mirror_q[i*LANE_W +: LANE_W] = lane_q[i];
  end
endmodule

// File: rtl/lext_ctrl.sv
module lext_ctrl
  import lext_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LANES       = 2,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned MIRROR_ADDR = 'h40,
  localparam int unsigned DATA_W     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ext_data,
  output logic [LANES-1:0]  ext_stb
);
  phase_e            phase;
  logic              cap_write;
  logic              cap_hit;
  logic [DATA_W-1:0] cap_wdata;
  logic [LANES-1:0]  cap_be;
  logic [LANES-1:0]  lane_fire;
  logic [DATA_W-1:0] mirror_q;

  lext_bus_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .MIRROR_ADDR(MIRROR_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_ready (req_ready),
    .phase     (phase),
    .cap_write (cap_write),
    .cap_hit   (cap_hit),
    .cap_wdata (cap_wdata),
    .cap_be    (cap_be)
  );

  lext_strobe #(.LANES(LANES), .LANE_W(LANE_W)) u_stb (
    .rst_n     (rst_n),
    .phase     (phase),
    .cap_write (cap_write),
    .cap_hit   (cap_hit),
    .cap_wdata (cap_wdata),
    .cap_be    (cap_be),
    .lane_fire (lane_fire),
    .ext_stb   (ext_stb),
    .ext_data  (ext_data)
  );

  lext_mirror #(.LANES(LANES), .LANE_W(LANE_W)) u_mir (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_lane (lane_fire),
    .upd_data (cap_wdata),
    .mirror_q (mirror_q)
  );

  assign rsp_valid = rst_n && (phase == PH_T4);
  assign rsp_rdata = (rsp_valid && cap_hit) ? mirror_q : '0;
endmodule

// File: rtl/lext_ctrl_chk.sv
module lext_ctrl_chk #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LANES       = 2,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned MIRROR_ADDR = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] ext_data,
  input logic [LANES-1:0]  ext_stb,
  input logic [DATA_W-1:0] mirror_q
);
  always_comb begin
    if (!rst_n) begin
      p_reset_drive_r2: assert ((&ext_stb) && (ext_data == '0) && !req_ready && !rsp_valid);
    end
  end

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_stb) |=> !(|ext_stb));

  p_no_stray_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && !(req_write && (req_addr == ADDR_W'(MIRROR_ADDR))), 3)
      |-> (ext_stb == '0));

  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_stb) |-> $stable(ext_data));

  p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|ext_stb) |-> $stable(mirror_q));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind lext_ctrl lext_ctrl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W), .MIRROR_ADDR(MIRROR_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .ext_data  (ext_data),
  .ext_stb   (ext_stb),
  .mirror_q  (mirror_q)
);

// File: tb/lext_ctrl_tb_top.sv
module lext_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ext_data;
  logic [1:0]  ext_stb;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int          m_phase = 0;
  logic        m_w = 1'b0;
  logic        m_hit = 1'b0;
  logic [15:0] m_wd = '0;
  logic [1:0]  m_be = '0;
  logic [15:0] m_mir = '0;

  lext_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_data(ext_data), .ext_stb(ext_stb)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mir = '0; m_w = 1'b0; m_hit = 1'b0; m_wd = '0; m_be = '0;
    end else if (m_phase == 0) begin
      if (req_valid) begin
        m_phase = 1; m_w = req_write; m_hit = (req_addr == 8'h40);
        m_wd = req_wdata; m_be = req_be;
      end
    end else begin
      if (m_phase == 3 && m_w && m_hit) begin
        if (m_be[0]) m_mir[7:0]  = m_wd[7:0];
        if (m_be[1]) m_mir[15:8] = m_wd[15:8];
      end
      m_phase = (m_phase == 4) ? 0 : m_phase + 1;
    end
  end

  logic        e_ready, e_rv;
  logic [1:0]  e_stb;
  logic [15:0] e_data, e_rd;
  always @(negedge clk) begin
    if (cmp_on) begin
      e_ready = rst_n && (m_phase == 0);
      for (int i = 0; i < 2; i++)
        e_stb[i] = !rst_n || (m_phase == 3 && m_w && m_hit && m_be[i]);
      e_data = (rst_n && m_phase != 0 && m_w && m_hit) ? m_wd : 16'h0;
      e_rv   = rst_n && (m_phase == 4);
      e_rd   = m_hit ? m_mir : 16'h0;
      chk(req_ready === e_ready, "R1 req_ready", 32'(req_ready), 32'(e_ready));
      chk(ext_stb === e_stb, rst_n ? "R4 ext_stb" : "R2 ext_stb", 32'(ext_stb), 32'(e_stb));
      chk(ext_data === e_data, "R6 ext_data", 32'(ext_data), 32'(e_data));
      chk(rsp_valid === e_rv, "R8 rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk(rsp_rdata === e_rd, "R8 rsp_rdata", 32'(rsp_rdata), 32'(e_rd));
    end
  end

  // called at a falling edge; returns at the falling edge inside T4
  task automatic txn(input bit w, input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] be, input bit scramble, output logic [15:0] rd);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (m_phase != 1);
    req_valid = 1'b0;
    if (scramble) begin
      req_write = ~w; req_addr = a ^ 8'h5A; req_wdata = ~d; req_be = ~be;
    end
    do @(negedge clk); while (m_phase != 4);
    rd = rsp_rdata;
  endtask

  task automatic reset_pulse();
    @(posedge clk); #5 rst_n = 1'b0;
    @(negedge clk);
    chk(ext_stb === 2'b11, "R2 strobes in reset", 32'(ext_stb), 32'h3);
    chk(ext_data === 16'h0, "R2 data in reset", 32'(ext_data), 32'h0);
    chk(req_ready === 1'b0, "R2 ready in reset", 32'(req_ready), 32'h0);
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    chk(ext_stb === 2'b11, "R2 strobes at start", 32'(ext_stb), 32'h3);
    chk(ext_data === 16'h0, "R2 data at start", 32'(ext_data), 32'h0);
    @(posedge clk); #5 rst_n = 1'b1;
    @(negedge clk);

    txn(1'b0, 8'h40, 16'h0, 2'b00, 1'b0, rd);
    chk(rd === 16'h0, "R3 mirror after reset", 32'(rd), 32'h0);

    txn(1'b1, 8'h40, 16'hA55A, 2'b11, 1'b0, rd);
    chk(rd === 16'hA55A, "R7 full write", 32'(rd), 32'hA55A);

    txn(1'b1, 8'h40, 16'h1234, 2'b01, 1'b0, rd);
    chk(rd === 16'hA534, "R7 low byte only", 32'(rd), 32'hA534);

    txn(1'b1, 8'h40, 16'hFF00, 2'b10, 1'b0, rd);
    chk(rd === 16'hFF34, "R7 high byte only", 32'(rd), 32'hFF34);

    txn(1'b1, 8'h40, 16'h0000, 2'b00, 1'b0, rd);
    chk(rd === 16'hFF34, "R7 no enables", 32'(rd), 32'hFF34);

    txn(1'b1, 8'h41, 16'hDEAD, 2'b11, 1'b0, rd);
    chk(rd === 16'h0, "R8 other address returns zero", 32'(rd), 32'h0);
    txn(1'b0, 8'h40, 16'h0, 2'b11, 1'b0, rd);
    chk(rd === 16'hFF34, "R5 foreign write ignored", 32'(rd), 32'hFF34);

    txn(1'b1, 8'h40, 16'h0F0F, 2'b11, 1'b1, rd);
    chk(rd === 16'h0F0F, "R9 scrambled after accept", 32'(rd), 32'h0F0F);
    txn(1'b0, 8'h40, 16'h0, 2'b00, 1'b0, rd);
    chk(rd === 16'h0F0F, "R9 readback", 32'(rd), 32'h0F0F);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      a = (($urandom % 5) == 0) ? 8'h40 + 8'(($urandom % 3) + 1) : 8'h40;
      txn(($urandom % 4) != 0, a, 16'($urandom), 2'($urandom), k[0], rd);
    end

    reset_pulse();
    txn(1'b0, 8'h40, 16'h0, 2'b11, 1'b0, rd);
    chk(rd === 16'h0, "R3 mirror cleared by reset", 32'(rd), 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule